// File: doc/BRIEF.md
# Tag memory write-rule controller

This block sits behind the command decoder of a contactless memory tag. It keeps sixteen 32-bit blocks and one system word at address 255, and it decides for each write whether the block takes it and what value is stored. Each address region has its own update rule. Blocks 0 to 4 only let bits go from 1 to 0. Blocks 5 and 6 are down-counters that accept only a strictly lower value. Blocks 7 to 15 are fully replaced on each write. The system word only lets bits clear, and its low byte holds a fixed chip identifier.

Write protection comes from the upper half of the system word. A shadow copy of that half governs writes, and only a select event refreshes the copy. A write to counter block 6 that alters any of its top eleven bits arms an erase mode. While the mode is armed, writes to blocks 0 to 4 replace the contents, so even an all-zero block can be written again. The mode holds until the next select event or a reset.

An accepted write opens a programming window of `PROG_CYCLES` clock cycles, and the value commits only at the end of that window. An abort input during the window drops the write and models a loss of power. During the window the block ignores requests.

Top module: `tagmem_write_ctrl`

## Requirements
- R1: After reset, blocks 0..4 and 7..15 read FFFFFFFFh, block 5 reads FFFFFFFEh, block 6 reads FFFFFFFFh, the system word reads {24'hFFFFFF, CHIP_ID}, and `rd_valid`, `wr_accept` and `busy` are low.
- R2: A read request to address 0..15 or 255, sampled while idle, raises `rd_valid` for exactly one cycle on the following cycle, and `rd_data` then carries the stored word.
- R3: Read or write requests to addresses 16..254 raise neither `rd_valid` nor `wr_accept`, and they change no stored word.
- R4: Outside erase mode, a write to an unprotected block 0..4 stores old AND data. A write to such a block that already holds all zeros is rejected, and `wr_accept` stays low.
- R5: A write to an unprotected block 5 or 6 is accepted only when the data is strictly lower, unsigned, than the stored value. Otherwise it is rejected and the block is unchanged.
- R6: A committed write to block 6 that changes any of bits 31..21 arms erase mode. In erase mode, writes to unprotected blocks 0..4 store the data as given, including writes to all-zero blocks. A select event disarms the mode.
- R7: A write to an unprotected block 7..15 replaces the whole word with the data.
- R8: A write to address 255 is always accepted. It stores old AND data in bits 31..8 and leaves bits 7..0 at CHIP_ID.
- R9: Block n is write-protected when bit n of the active lock copy is 0, and a write to it is rejected. The active lock copy is loaded from bits 31..16 of the system word only on a select event. Its reset value is all ones.
- R10: An accepted write raises `wr_accept` for one cycle and `busy` on the cycle after the request. `busy` then stays high for `PROG_CYCLES` cycles, and the new value is readable after it falls. Requests presented while `busy` is high get no response.
- R11: `abort` high while `busy` is high discards the pending write. `busy` falls on the next cycle and the stored word keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 8 | Block address |
| req_data | input | 32 | Write data |
| select_evt | input | 1 | Select event: loads the lock copy, disarms erase mode |
| abort | input | 1 | Drops the pending write during the programming window |
| rd_valid | output | 1 | Read response enable, one cycle |
| rd_data | output | 32 | Read data, valid while rd_valid is high |
| wr_accept | output | 1 | Write accepted, one cycle |
| busy | output | 1 | Programming window in progress |

## Verification
`rd_valid`, `rd_data` and `wr_accept` are registered, so each is due one cycle after the request is sampled. `busy` rises in that same cycle and falls `PROG_CYCLES` cycles later, and only then is the committed value readable. The bench drives requests on falling edges and samples one falling edge later. After an accept it waits exactly `PROG_CYCLES` more falling edges before it checks that `busy` has dropped and updates its reference model. The checks for abort and for requests made while busy fall one edge into the window, and those edges are counted the same way.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } fsm_t;

    typedef enum logic [2:0] {
        RG_OTP,
        RG_CNT,
        RG_EEP,
        RG_SYS,
        RG_NONE
    } region_t;

    function automatic region_t region_of(input int a, input int otp_last,
                                          input int cnt_last, input int nblk,
                                          input int sys_addr);
        if (a <= otp_last)      return RG_OTP;
        else if (a <= cnt_last) return RG_CNT;
        else if (a < nblk)      return RG_EEP;
        else if (a == sys_addr) return RG_SYS;
        else                    return RG_NONE;
    endfunction

endpackage

// File: rtl/tagmem_rule.sv
module tagmem_rule
    import tagmem_pkg::*;
#(
    parameter int DW   = 32,
    parameter int ID_W = 8
) (
    input  region_t          rg,
    input  logic [DW-1:0]    old_w,
    input  logic [DW-1:0]    wdata,
    input  logic             erase_mode,
    input  logic             locked,
    output logic             allow,
    output logic [DW-1:0]    new_w
);

    always_comb begin
        allow = 1'b0;
        new_w = old_w;
        unique case (rg)
            RG_OTP: begin
                if (erase_mode) begin
                    allow = !locked;
                    new_w = wdata;
                end else begin
                    allow = !locked && (old_w != '0);
                    new_w = old_w & wdata;
                end
            end
            RG_CNT: begin
                allow = !locked && (wdata < old_w);
                new_w = wdata;
            end
            RG_EEP: begin
                allow = !locked;
                new_w = wdata;
            end
            RG_SYS: begin
                allow = 1'b1;
                new_w = {old_w[DW-1:ID_W] & wdata[DW-1:ID_W], old_w[ID_W-1:0]};
            end
            default: begin
                allow = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tagmem_store.sv
module tagmem_store #(
    parameter int             DW        = 32,
    parameter int             NBLK      = 16,
    parameter int             CNT_FIRST = 5,
    parameter int             ID_W      = 8,
    parameter logic [ID_W-1:0] CHIP_ID  = 8'h5A,
    localparam int            IW        = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sys,
    input  logic [IW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_val,
    output logic [DW-1:0]    blk_q [NBLK],
    output logic [DW-1:0]    sys_q
);

    logic [NBLK-1:0][DW-1:0] mem_q;

    function automatic logic [DW-1:0] reset_word(input int i);
        if (i == CNT_FIRST) return {{(DW-1){1'b1}}, 1'b0};
        return '1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) mem_q[i] <= reset_word(i);
        end else if (wr_en && !wr_sys) begin
            mem_q[wr_idx] <= wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               sys_q <= {{(DW-ID_W){1'b1}}, CHIP_ID};
        else if (wr_en && wr_sys) sys_q <= wr_val;
    end

    for (genvar g = 0; g < NBLK; g++) begin : g_out
        assign blk_q[g] = mem_q[g];
    end

endmodule

// File: rtl/tagmem_write_ctrl.sv
module tagmem_write_ctrl
    import tagmem_pkg::*;
#(
    parameter int             DW          = 32,
    parameter int             AW          = 8,
    parameter int             NBLK        = 16,
    parameter int             OTP_LAST    = 4,
    parameter int             CNT_FIRST   = 5,
    parameter int             CNT_LAST    = 6,
    parameter int             SYS_ADDR    = 255,
    parameter int             ID_W        = 8,
    parameter int             LOCK_LSB    = 16,
    parameter int             RELOAD_LSB  = 21,
    parameter int             PROG_CYCLES = 8,
    parameter logic [ID_W-1:0] CHIP_ID    = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          select_evt,
    input  logic          abort,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          wr_accept,
    output logic          busy
);

    localparam int IW = $clog2(NBLK);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    fsm_t            state_q, state_nx;
    logic [DW-1:0]   blk_q [NBLK];
    logic [DW-1:0]   sys_q;
    region_t         rg;
    logic [IW-1:0]   idx;
    logic [DW-1:0]   old_w, new_w;
    logic            locked, allow, take, take_rd, take_wr, commit;
    logic [CW-1:0]   cnt_q;
    logic [DW-1:0]   pend_val;
    logic [IW-1:0]   pend_idx;
    logic            pend_sys;
    logic            erase_q;
    logic [NBLK-1:0] act_lock;
    logic [DW-1:0]   cnt_lo_q, cnt_hi_q;
    logic            reload_hit;

    // Request decode
    always_comb begin
        rg     = region_of(int'(req_addr), OTP_LAST, CNT_LAST, NBLK, SYS_ADDR);
        idx    = req_addr[IW-1:0];
        old_w  = (rg == RG_SYS) ? sys_q : blk_q[idx];
        locked = (rg inside {RG_OTP, RG_CNT, RG_EEP}) && !act_lock[idx];
    end

    tagmem_rule #(.DW(DW), .ID_W(ID_W)) u_rule (
        .rg         (rg),
        .old_w      (old_w),
        .wdata      (req_data),
        .erase_mode (erase_q),
        .locked     (locked),
        .allow      (allow),
        .new_w      (new_w)
    );

    assign take    = req_valid && (state_q == ST_IDLE);
    assign take_rd = take && !req_write && (rg != RG_NONE);
    assign take_wr = take && req_write && allow;
    assign commit  = (state_q == ST_BUSY) && !abort && (cnt_q == '0);
    assign reload_hit = commit && !pend_sys && (int'(pend_idx) == CNT_LAST) &&
                        (blk_q[pend_idx][DW-1:RELOAD_LSB] != pend_val[DW-1:RELOAD_LSB]);

    tagmem_store #(
        .DW(DW), .NBLK(NBLK), .CNT_FIRST(CNT_FIRST), .ID_W(ID_W), .CHIP_ID(CHIP_ID)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (commit),
        .wr_sys (pend_sys),
        .wr_idx (pend_idx),
        .wr_val (pend_val),
        .blk_q  (blk_q),
        .sys_q  (sys_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (take_wr) state_nx = ST_BUSY;
            ST_BUSY: if (abort || cnt_q == '0) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            wr_accept <= 1'b0;
            cnt_q     <= '0;
            pend_val  <= '0;
            pend_idx  <= '0;
            pend_sys  <= 1'b0;
            erase_q   <= 1'b0;
            act_lock  <= '1;
        end else begin
            rd_valid  <= take_rd;
            wr_accept <= take_wr;
            if (take_rd) rd_data <= old_w;
            if (take_wr) begin
                pend_val <= new_w;
                pend_idx <= idx;
                pend_sys <= (rg == RG_SYS);
                cnt_q    <= CW'(PROG_CYCLES - 1);
            end else if (state_q == ST_BUSY && cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
            end
            if (select_evt)      erase_q <= 1'b0;
            else if (reload_hit) erase_q <= 1'b1;
            if (select_evt) act_lock <= sys_q[LOCK_LSB +: NBLK];
        end
    end

    assign busy     = (state_q == ST_BUSY);
    assign cnt_lo_q = blk_q[CNT_FIRST];
    assign cnt_hi_q = blk_q[CNT_LAST];

endmodule

// File: rtl/tagmem_checker.sv
module tagmem_checker #(
    parameter int DW       = 32,
    parameter int AW       = 8,
    parameter int NBLK     = 16,
    parameter int SYS_ADDR = 255
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [AW-1:0]   req_addr,
    input logic            abort,
    input logic            select_evt,
    input logic            busy,
    input logic            rd_valid,
    input logic            wr_accept,
    input logic [DW-1:0]   cnt_lo,
    input logic [DW-1:0]   cnt_hi,
    input logic [NBLK-1:0] act_lock
);

    logic in_hole;
    assign in_hole = (int'(req_addr) >= NBLK) && (int'(req_addr) != SYS_ADDR);

    AST_SINGLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_accept)); // R2

    AST_HOLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && in_hole) |=> (!rd_valid && !wr_accept)); // R3

    AST_CNT_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lo <= $past(cnt_lo)) && (cnt_hi <= $past(cnt_hi))); // R5

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !select_evt |=> $stable(act_lock)); // R9

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> busy); // R10

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !req_write) |=> (!rd_valid && !wr_accept)); // R10

    AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && $stable(cnt_lo) && $stable(cnt_hi))); // R11

endmodule

bind tagmem_write_ctrl tagmem_checker #(
    .DW(DW), .AW(AW), .NBLK(NBLK), .SYS_ADDR(SYS_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .abort      (abort),
    .select_evt (select_evt),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .wr_accept  (wr_accept),
    .cnt_lo     (cnt_lo_q),
    .cnt_hi     (cnt_hi_q),
    .act_lock   (act_lock)
);

// File: tb/tagmem_write_ctrl_test.sv
module tagmem_write_ctrl_test;

    localparam int         CLK_PERIOD = 10;
    localparam int         P          = 5;
    localparam logic [7:0] CID        = 8'hA7;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_data = '0;
    logic        select_evt = 1'b0, abort = 1'b0;
    logic        rd_valid, wr_accept, busy;
    logic [31:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_blk [16];
    logic [31:0] m_sys;
    logic        m_erase;
    logic [15:0] m_lock;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagmem_write_ctrl #(.PROG_CYCLES(P), .CHIP_ID(CID)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_data(req_data), .select_evt(select_evt),
        .abort(abort), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_accept(wr_accept), .busy(busy)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_blk[i] = (i == 5) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF;
        m_sys   = {24'hFFFFFF, CID};
        m_erase = 1'b0;
        m_lock  = 16'hFFFF;
    endtask

    function automatic bit exp_ok(int a, logic [31:0] d);
        if (a <= 4)   return m_lock[a] && (m_erase || m_blk[a] != 32'h0);
        if (a <= 6)   return m_lock[a] && (d < m_blk[a]);
        if (a <= 15)  return m_lock[a];
        if (a == 255) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_val(int a, logic [31:0] d);
        if (a <= 4)  return m_erase ? d : (m_blk[a] & d);
        if (a <= 15) return d;
        return {m_sys[31:8] & d[31:8], m_sys[7:0]};
    endfunction

    function automatic logic [31:0] model_word(int a);
        if (a == 255) return m_sys;
        if (a < 16)   return m_blk[a];
        return 32'h0;
    endfunction

    task automatic model_commit(int a, logic [31:0] d);
        logic [31:0] v = exp_val(a, d);
        if (a == 6 && m_blk[6][31:21] != v[31:21]) m_erase = 1'b1;
        if (a == 255)   m_sys = v;
        else if (a < 16) m_blk[a] = v;
    endtask

    task automatic send(bit wr, int a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a[7:0]; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(string req, int a, logic [31:0] d);
        bit ok = exp_ok(a, d);
        send(1'b1, a, d);
        check({req, " accept"}, {31'b0, wr_accept}, {31'b0, ok});
        if (ok) begin
            check({req, " busy high"}, {31'b0, busy}, 32'd1);
            repeat (P) @(negedge clk);
            check({req, " busy low"}, {31'b0, busy}, 32'd0);
            model_commit(a, d);
        end else begin
            check({req, " no busy"}, {31'b0, busy}, 32'd0);
        end
    endtask

    task automatic do_read(string req, int a);
        bit v = (a < 16) || (a == 255);
        send(1'b0, a, 32'h0);
        check({req, " valid"}, {31'b0, rd_valid}, {31'b0, v});
        if (v) check({req, " data"}, rd_data, model_word(a));
    endtask

    task automatic pulse_select();
        @(negedge clk);
        select_evt = 1'b1;
        @(negedge clk);
        select_evt = 1'b0;
        m_erase = 1'b0;
        m_lock  = m_sys[31:16];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240613);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R1 wr_accept", {31'b0, wr_accept}, 32'd0);
        for (int a = 0; a < 16; a++) do_read("R1 reset block", a);
        do_read("R2 sys read", 255);
        check("R1 sys literal", rd_data, 32'hFFFF_FFA7);
        do_read("R2 read", 5);
        check("R1 counter literal", rd_data, 32'hFFFF_FFFE);

        // R4 bit-clear region
        do_write("R4 clear", 2, 32'h0F0F_FFFF);
        do_read("R4", 2);
        check("R4 and literal", rd_data, 32'h0F0F_FFFF);
        do_write("R4 empty", 2, 32'hF0F0_0000);
        do_write("R4 reject empty", 2, 32'hFFFF_FFFF);
        do_read("R4", 2);
        check("R4 empty literal", rd_data, 32'h0);

        // R5 counters
        do_write("R5 equal", 5, 32'hFFFF_FFFE);
        do_write("R5 lower", 5, 32'h0000_1000);
        do_write("R5 higher", 5, 32'h0000_2000);
        do_read("R5", 5);
        check("R5 literal", rd_data, 32'h0000_1000);

        // R6 reload
        do_write("R6 no arm", 6, 32'hFFFF_0000);
        do_write("R6 still empty", 2, 32'h0000_1234);
        do_write("R6 arm", 6, 32'h0FFF_FFFF);
        do_write("R6 reload", 2, 32'h0000_1234);
        do_read("R6", 2);
        check("R6 reload literal", rd_data, 32'h0000_1234);
        do_write("R6 replace", 2, 32'h0000_5678);
        do_read("R6", 2);
        check("R6 replace literal", rd_data, 32'h0000_5678);
        pulse_select();
        do_write("R6 disarmed", 2, 32'h0000_0F0F);
        do_read("R6", 2);
        check("R6 disarm literal", rd_data, 32'h0000_0608);

        // R7 full replace
        do_write("R7", 9, 32'h1234_5678);
        do_write("R7", 9, 32'hFFFF_0000);
        do_read("R7", 9);
        check("R7 literal", rd_data, 32'hFFFF_0000);

        // R8 system word
        do_write("R8", 255, 32'hFFFF_FE00);
        do_read("R8", 255);
        check("R8 literal", rd_data, 32'hFFFF_FEA7);

        // R9 lock via select
        do_write("R9 lock bit", 255, 32'hFEFF_FFFF);
        do_write("R9 before select", 8, 32'h1111_1111);
        pulse_select();
        do_write("R9 locked", 8, 32'h2222_2222);
        do_read("R9", 8);
        check("R9 literal", rd_data, 32'h1111_1111);
        do_write("R9 neighbour", 9, 32'h3333_3333);

        // R3 address hole
        do_read("R3 hole", 16);
        do_read("R3 hole", 200);
        do_read("R3 hole", 254);
        do_write("R3 hole", 254, 32'h0);
        do_write("R3 hole", 100, 32'h0);
        do_read("R3 after hole", 9);
        check("R3 literal", rd_data, 32'h3333_3333);

        // R10 request while busy
        send(1'b1, 7, 32'hCAFE_0001);
        check("R10 accept", {31'b0, wr_accept}, 32'd1);
        check("R10 busy", {31'b0, busy}, 32'd1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd9;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 ignored", {31'b0, rd_valid}, 32'd0);
        check("R10 still busy", {31'b0, busy}, 32'd1);
        repeat (P - 1) @(negedge clk);
        check("R10 busy done", {31'b0, busy}, 32'd0);
        model_commit(7, 32'hCAFE_0001);
        do_read("R10 commit", 7);
        check("R10 literal", rd_data, 32'hCAFE_0001);

        // R11 abort
        send(1'b1, 10, 32'h0BAD_0BAD);
        check("R11 accept", {31'b0, wr_accept}, 32'd1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R11 busy drop", {31'b0, busy}, 32'd0);
        do_read("R11 keep", 10);
        check("R11 literal", rd_data, 32'hFFFF_FFFF);
        send(1'b1, 5, 32'h0000_0010);
        check("R11 counter accept", {31'b0, wr_accept}, 32'd1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        do_read("R11 counter keep", 5);
        check("R11 counter literal", rd_data, 32'h0000_1000);

        // Random mix
        for (int k = 0; k < 300; k++) begin
            int r = int'($urandom % 100);
            if (r < 5) begin
                pulse_select();
            end else if (r < 15) begin
                int h = 16 + int'($urandom % 239);
                if (r[0]) do_write("R3 random hole", h, $urandom);
                else      do_read("R3 random hole", h);
            end else if (r < 20) begin
                do_read("R8 random", 255);
            end else if (r < 22) begin
                do_write("R8 random", 255, ~(32'h1 << (8 + ($urandom % 24))));
            end else begin
                int a = int'($urandom % 16);
                logic [31:0] d;
                if (r < 55) begin
                    do_read("R2 random", a);
                end else if (a >= 5 && a <= 6) begin
                    d = ($urandom % 3 == 0) ? $urandom : (m_blk[a] - ($urandom % 4096));
                    do_write("R5 random", a, d);
                end else if (a <= 4) begin
                    d = $urandom | $urandom | $urandom;
                    do_write("R4 random", a, d);
                end else begin
                    do_write("R7 random", a, $urandom);
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule